// File: doc/BRIEF.md
# Latched-Operand ALU with Compare Modifiers

This block is the arithmetic stage of a microcoded processor. Two operand registers, A and B, are each loaded from a source multiplexer when their load bit is set, and hold their value otherwise. Each cycle the block applies the selected operation to the held operands and stores the result in a result register. A result therefore appears one cycle after its operation is selected, and two cycles after its operands are chosen.

A single unsigned less-than compare also serves as the signed compare and the greater-or-equal compares. An input modifier flips the top bit of both operands before the operation. An output modifier can invert the result's bit 0, or clear it to align a jump target. A zero flag for the registered result goes to the sequencer for conditional branching. Shifts move by a single amount taken from B. The microcode builds longer shifts by repeating them one bit at a time.

Top module: `latched_operand_alu`

## Requirements
- R1: After reset, A, B and the result register are all zero, and `result_zero` is 1.
- R2: When `a_load` is 1, A takes the source picked by `a_pick`: 0 gp, 1 immediate, 2 current result register, 3 zero, 4 four, 5 all ones, 6 thirty-one, 7 zero.
- R3: When `b_load` is 1, B takes the source picked by `b_pick`: 0 gp, 1 pc, 2 immediate, 3 one, 4 read data, 5 CSR immediate, 6 CSR value, 7 cause.
- R4: When its load bit is 0, an operand register keeps its value whatever its source inputs do.
- R5: On every clock edge the result register takes `op` applied to the current A and B. The codes are 0 add, 1 subtract (A−B), 2 and, 3 or, 4 xor.
- R6: Codes 5 (shift left), 6 (logical shift right) and 7 (arithmetic shift right, copying bit 31) shift A by the low 5 bits of B only.
- R7: Code 8 gives 1 when A < B unsigned, else 0. No other bit of the result is set.
- R8: When `in_mod` is 1, bit 31 of both A and B is inverted before the operation. Code 8 then gives a signed less-than.
- R9: `out_mod` 1 inverts bit 0 of the result, 2 forces bit 0 to 0, and 0 or 3 leaves the result unchanged.
- R10: `result_zero` is 1 exactly when the registered result is all zeros.
- R11: Op codes 9 to 15 give zero before the output modifier is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_load | input | 1 | Load enable for A |
| a_pick | input | 3 | A source select |
| b_load | input | 1 | Load enable for B |
| b_pick | input | 3 | B source select |
| op | input | 4 | Operation code |
| in_mod | input | 1 | Invert operand MSBs |
| out_mod | input | 2 | Result bit-0 modifier |
| gp_val | input | 32 | General-purpose register value |
| pc_val | input | 32 | Program counter |
| imm_val | input | 32 | Immediate |
| rdata_val | input | 32 | Memory read data |
| csr_imm_val | input | 32 | CSR immediate |
| csr_val | input | 32 | CSR value |
| cause_val | input | 32 | Latched trap cause |
| result | output | 32 | Registered result |
| result_zero | output | 1 | Registered result is zero |

## Verification
The hardest case to reach is one where the operands differ only across the sign boundary. Here, flipping the top bit changes the compare outcome, and an inverted or cleared bit 0 must interact correctly with that outcome. Random picks rarely produce it. Directed steps therefore load all-ones and one, and run the compare under every combination of the two modifiers. Around those steps, a cycle-by-cycle random run feeds the result back through the A source and changes source inputs while loads are off. This exercises the hold paths and the two-register latency.

// File: rtl/latched_operand_alu.sv
`timescale 1ns/1ps
module latched_operand_alu #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             a_load,
  input  logic [2:0]       a_pick,
  input  logic             b_load,
  input  logic [2:0]       b_pick,
  input  logic [3:0]       op,
  input  logic             in_mod,
  input  logic [1:0]       out_mod,
  input  logic [WIDTH-1:0] gp_val,
  input  logic [WIDTH-1:0] pc_val,
  input  logic [WIDTH-1:0] imm_val,
  input  logic [WIDTH-1:0] rdata_val,
  input  logic [WIDTH-1:0] csr_imm_val,
  input  logic [WIDTH-1:0] csr_val,
  input  logic [WIDTH-1:0] cause_val,
  output logic [WIDTH-1:0] result,
  output logic             result_zero
);
  localparam int SHW = $clog2(WIDTH);
  localparam logic [WIDTH-1:0] MSB = {1'b1, {(WIDTH-1){1'b0}}};

  logic [WIDTH-1:0] a_q, b_q, a_src, b_src, a_eff, b_eff, raw, res_d;
  logic [SHW-1:0]   sh;
  logic             zero_q;

  always_comb begin
    case (a_pick)
      3'd0:    a_src = gp_val;
      3'd1:    a_src = imm_val;
      3'd2:    a_src = result;
      3'd4:    a_src = WIDTH'(4);
      3'd5:    a_src = '1;
      3'd6:    a_src = WIDTH'(31);
      default: a_src = '0;
    endcase
  end

  always_comb begin
    case (b_pick)
      3'd0:    b_src = gp_val;
      3'd1:    b_src = pc_val;
      3'd2:    b_src = imm_val;
      3'd3:    b_src = WIDTH'(1);
      3'd4:    b_src = rdata_val;
      3'd5:    b_src = csr_imm_val;
      3'd6:    b_src = csr_val;
      default: b_src = cause_val;
    endcase
  end

  assign a_eff = in_mod ? (a_q ^ MSB) : a_q;
  assign b_eff = in_mod ? (b_q ^ MSB) : b_q;
  assign sh    = b_eff[SHW-1:0];

  always_comb begin
    case (op)
      4'd0:    raw = a_eff + b_eff;
      4'd1:    raw = a_eff - b_eff;
      4'd2:    raw = a_eff & b_eff;
      4'd3:    raw = a_eff | b_eff;
      4'd4:    raw = a_eff ^ b_eff;
      4'd5:    raw = a_eff << sh;
      4'd6:    raw = a_eff >> sh;
      4'd7:    raw = WIDTH'($signed(a_eff) >>> sh);
      4'd8:    raw = WIDTH'(a_eff < b_eff);
      default: raw = '0;
    endcase
  end

  always_comb begin
    case (out_mod)
      2'd1:    res_d = raw ^ WIDTH'(1);
      2'd2:    res_d = raw & ~WIDTH'(1);
      default: res_d = raw;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q    <= '0;
      b_q    <= '0;
      result <= '0;
      zero_q <= 1'b1;
    end else begin
      if (a_load) a_q <= a_src;
      if (b_load) b_q <= b_src;
      result <= res_d;
      zero_q <= (res_d == '0);
    end
  end

  assign result_zero = zero_q;

  assert_a_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !a_load |=> $stable(a_q));
  assert_b_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !b_load |=> $stable(b_q));
  assert_a_zero_src_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (a_load && a_pick == 3'd3) |=> (a_q == '0));
  assert_b_one_src_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (b_load && b_pick == 3'd3) |=> (b_q == WIDTH'(1)));
  assert_cmp_bool_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 4'd8 && out_mod != 2'd1) |=> (result[WIDTH-1:1] == '0));
  assert_clear_lsb_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_mod == 2'd2) |=> !result[0]);
  assert_zero_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    result_zero == (result == '0));
  assert_undef_op_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (op > 4'd8 && out_mod != 2'd1) |=> (result == '0));
endmodule

// File: tb/latched_operand_alu_test.sv
`timescale 1ns/1ps
module latched_operand_alu_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic a_load = 0, b_load = 0, in_mod = 0;
  logic [2:0] a_pick = 0, b_pick = 0;
  logic [3:0] op = 0;
  logic [1:0] out_mod = 0;
  logic [31:0] gp = 0, pcv = 0, imm = 0, rd = 0, cimm = 0, csr = 0, cause = 0;
  logic [31:0] result;
  logic result_zero;
  logic [31:0] ma = 0, mb = 0, mr = 0;
  int checks = 0, failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  latched_operand_alu uut (
    .clk(clk), .rst_n(rst_n), .a_load(a_load), .a_pick(a_pick),
    .b_load(b_load), .b_pick(b_pick), .op(op), .in_mod(in_mod),
    .out_mod(out_mod), .gp_val(gp), .pc_val(pcv), .imm_val(imm),
    .rdata_val(rd), .csr_imm_val(cimm), .csr_val(csr), .cause_val(cause),
    .result(result), .result_zero(result_zero));

  function automatic logic [31:0] pick_a(input logic [2:0] p);
    case (p)
      0: return gp;  1: return imm;  2: return mr;  4: return 32'd4;
      5: return 32'hFFFF_FFFF;  6: return 32'd31;  default: return 32'd0;
    endcase
  endfunction

  function automatic logic [31:0] pick_b(input logic [2:0] p);
    case (p)
      0: return gp;  1: return pcv;  2: return imm;  3: return 32'd1;
      4: return rd;  5: return cimm;  6: return csr;  default: return cause;
    endcase
  endfunction

  function automatic logic [31:0] model(input logic [31:0] a, input logic [31:0] b,
      input logic [3:0] o, input logic im, input logic [1:0] om);
    logic [31:0] x, y, r;
    x = im ? {~a[31], a[30:0]} : a;
    y = im ? {~b[31], b[30:0]} : b;
    case (o)
      0: r = x + y;  1: r = x - y;  2: r = x & y;  3: r = x | y;  4: r = x ^ y;
      5: r = x << y[4:0];
      6: r = x >> y[4:0];
      7: r = $unsigned($signed(x) >>> y[4:0]);
      8: r = (x < y) ? 32'd1 : 32'd0;
      default: r = 0;
    endcase
    if (om == 1) r[0] = ~r[0];
    else if (om == 2) r[0] = 1'b0;
    return r;
  endfunction

  function automatic string tag_of(input logic [3:0] o, input logic im, input logic [1:0] om);
    if (om == 1 || om == 2) return "R9";
    if (im) return "R8";
    if (o <= 4) return "R5";
    if (o <= 7) return "R6";
    if (o == 8) return "R7";
    return "R11";
  endfunction

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic al, input logic [2:0] ap, input logic bl,
      input logic [2:0] bp, input logic [3:0] o, input logic im,
      input logic [1:0] om, input string tag);
    logic [31:0] na, nb, nr;
    @(negedge clk);
    a_load = al; a_pick = ap; b_load = bl; b_pick = bp;
    op = o; in_mod = im; out_mod = om;
    na = al ? pick_a(ap) : ma;
    nb = bl ? pick_b(bp) : mb;
    nr = model(ma, mb, o, im, om);
    @(posedge clk); #1;
    ma = na; mb = nb; mr = nr;
    check(result, mr, (tag == "") ? tag_of(o, im, om) : tag);
    check({31'd0, result_zero}, {31'd0, mr == 0}, "R10");
  endtask

  initial begin
    #1_000_000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    #1;
    check(result, 32'd0, "R1");
    check({31'd0, result_zero}, 32'd1, "R1");
    @(negedge clk); rst_n = 1'b1;
    step(0, 0, 0, 0, 4'd0, 0, 0, "R1");

    // R4 hold: load A from gp, then change gp with loads off
    gp = 32'd5;
    step(1, 0, 1, 3, 4'd0, 0, 0, "R2");
    gp = 32'd900; pcv = 32'd77;
    step(0, 0, 0, 1, 4'd0, 0, 0, "R4");
    check(result, 32'd6, "R4");

    // R2 result feedback and constants
    step(1, 2, 1, 7, 4'd0, 0, 0, "R2");
    cause = 32'd10;
    step(1, 6, 1, 7, 4'd3, 0, 0, "R3");
    step(0, 0, 0, 0, 4'd0, 0, 0, "R2");
    check(result, 32'd41, "R3");

    // signed / greater-or-equal compares around the sign boundary
    step(1, 5, 1, 3, 4'd0, 0, 0, "R5");
    step(0, 0, 0, 0, 4'd8, 0, 0, "R7");
    check(result, 32'd0, "R7");
    step(0, 0, 0, 0, 4'd8, 1, 0, "R8");
    check(result, 32'd1, "R8");
    step(0, 0, 0, 0, 4'd8, 0, 1, "R9");
    check(result, 32'd1, "R9");
    step(0, 0, 0, 0, 4'd8, 1, 1, "R9");
    check(result, 32'd0, "R9");

    // R6 shift amount uses low 5 bits only; sra copies bit 31
    imm = 32'h8000_0001; gp = 32'd33;
    step(1, 1, 1, 0, 4'd0, 0, 0, "R6");
    step(0, 0, 0, 0, 4'd5, 0, 0, "R6");
    check(result, 32'h0000_0002, "R6");
    gp = 32'd4;
    step(0, 0, 1, 0, 4'd0, 0, 0, "R6");
    step(0, 0, 0, 0, 4'd7, 0, 0, "R6");
    check(result, 32'hF800_0000, "R6");
    step(0, 0, 0, 0, 4'd6, 0, 0, "R6");
    check(result, 32'h0800_0000, "R6");

    // R9 clear bit 0 on odd sum, R11 undefined op
    step(0, 0, 0, 0, 4'd0, 0, 2, "R9");
    check(result, 32'h8000_0004, "R9");
    step(0, 0, 0, 0, 4'd12, 0, 0, "R11");
    check(result, 32'd0, "R11");
    step(0, 0, 0, 0, 4'd15, 0, 1, "R11");
    check(result, 32'd1, "R11");

    for (int i = 0; i < 4000; i++) begin
      gp = $urandom; pcv = $urandom; imm = $urandom; rd = $urandom;
      cimm = $urandom; csr = $urandom; cause = $urandom;
      if (($urandom % 4) == 0) gp = 32'h8000_0000 ^ ($urandom % 3);
      step($urandom % 2 == 1, 3'($urandom), $urandom % 2 == 1, 3'($urandom),
           4'($urandom % 11), ($urandom % 3) == 0, 2'($urandom), "");
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule